// File: doc/BRIEF.md
# Peripheral Command Mailbox

This block is the CPU-facing side of a single peripheral. It occupies a short, configurable run of word addresses in the 16-bit address space and presents them as a shared window. Offset 0 of the window is a status/command word. The offsets after it are a small data buffer. Both the CPU bus and the device engine can read and write the buffer.

The CPU starts a transfer with an ordinary store to the status word and then carries on with other work. The device engine pulls the requested number of words from the medium into the buffer. The medium is modelled as a source with a request/valid pair. When the engine is done it raises an interrupt request. The CPU then reads the buffer, which withdraws the request, and may issue the next command. This command, fill, interrupt and read cycle repeats as often as the software needs.

The engine has three states:
- `ENG_IDLE` waits for a command.
- `ENG_FETCH` requests and stores medium words.
- `ENG_FINISH` is the single completion cycle.

It has three transitions:
- IDLE to FETCH on an accepted start.
- FETCH to FINISH when the last requested word is stored.
- FINISH to IDLE unconditionally.

Top module: `pmb_mailbox`

## Requirements
- R1: The window starts at `BASE_ADDR` and spans `BUF_WORDS`+1 words: the status word is at offset 0 and buffer word i is at offset i+1. A read inside the window returns data on `cpu_rdata` with `cpu_rvalid`=1 on the cycle after `cpu_rd`. A read outside the window gives `cpu_rvalid`=0 and `cpu_rdata`=0, and a write outside the window changes nothing.
- R2: After reset the following are all zero: the status word, `irq_req`, `med_req`, `cpu_rvalid` and every buffer word.
- R3: A write to the status word with bit 15 set, made while the engine is idle, starts a command. From the next cycle, status bit 0 (busy) reads 1 and status bit 1 (done) reads 0. The CPU bus is never stalled.
- R4: Status-write bits 11:8 give the word count n. A count of 0, or one above `BUF_WORDS`, means `BUF_WORDS`. The engine stores the medium words, in the order they are accepted, into buffer words 0 to n-1 and leaves the remaining buffer words untouched.
- R5: `med_req` is 1 from the cycle after an accepted start until the last word is accepted. A word is accepted on a clock edge where both `med_req` and `med_valid` are 1.
- R6: One cycle after `med_req` falls at the end of a command, busy clears, done (status bit 1) sets and `irq_req` rises.
- R7: A CPU read of any buffer word clears done and `irq_req` from the next cycle. A read of the status word leaves them unchanged.
- R8: A start written while busy is ignored: the count and fill are not affected. It sets status bit 2 (error). A status write with bit 14 set and bit 15 clear clears the error bit.
- R9: The CPU can write buffer words through the window and read them back unchanged.
- R10: Successive commands with different counts each complete and deliver the correct medium words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU word address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rdata | output | 16 | Read data, zero when not valid |
| cpu_rvalid | output | 1 | Read data valid for an in-window read |
| irq_req | output | 1 | Completion interrupt request |
| med_req | output | 1 | Engine requests a medium word |
| med_valid | input | 1 | Medium word available |
| med_data | input | 16 | Medium word |

## Verification
A wrong internal state shows up within a few cycles at the ports:
- A stuck engine state appears at once as `med_req` staying high or never rising after a start.
- A lost or spurious done flag shows as `irq_req` out of step, one cycle after `med_req` falls or one cycle after a buffer read.
- A wrong fill index or count shows on the next buffer read-back, as a misplaced medium word or an overwritten word beyond the count.
- An ignored command that leaks into the engine shows as extra words filled.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
    localparam int STAT_BUSY  = 0;
    localparam int STAT_DONE  = 1;
    localparam int STAT_ERR   = 2;
    localparam int CMD_START  = 15;
    localparam int CMD_ERRCLR = 14;
    localparam int CMD_CNT_LO = 8;
    localparam int CMD_CNT_W  = 4;

    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_FETCH  = 2'd1,
        ENG_FINISH = 2'd2
    } eng_state_e;
endpackage

// File: rtl/pmb_decode.sv
module pmb_decode #(
    parameter int AW        = 16,
    parameter logic [AW-1:0] BASE = 16'h8000,
    parameter int BUF_WORDS = 4,
    parameter int IDX_W     = 2
) (
    input  logic [AW-1:0]    addr,
    output logic             hit,
    output logic             hit_stat,
    output logic             hit_buf,
    output logic [IDX_W-1:0] buf_idx
);
    localparam logic [AW-1:0] WIN = AW'(BUF_WORDS + 1);

    logic [AW-1:0] offset;
    logic [AW-1:0] buf_off;

    always_comb begin
        offset   = addr - BASE;
        buf_off  = offset - AW'(1);
        hit      = (addr >= BASE) && (offset < WIN);
        hit_stat = hit && (offset == '0);
        hit_buf  = hit && (offset != '0);
        buf_idx  = buf_off[IDX_W-1:0];
    end
endmodule

// File: rtl/pmb_store.sv
module pmb_store #(
    parameter int DW        = 16,
    parameter int BUF_WORDS = 4,
    parameter int IDX_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_we,
    input  logic [IDX_W-1:0] cpu_idx,
    input  logic [DW-1:0]    cpu_wdata,
    input  logic             dev_we,
    input  logic [IDX_W-1:0] dev_idx,
    input  logic [DW-1:0]    dev_wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data
);
    logic [DW-1:0] word_q [BUF_WORDS];

    for (genvar i = 0; i < BUF_WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[i] <= '0;
            end else if (dev_we && (dev_idx == IDX_W'(i))) begin
                word_q[i] <= dev_wdata;
            end else if (cpu_we && (cpu_idx == IDX_W'(i))) begin
                word_q[i] <= cpu_wdata;
            end
        end

        // R4: a device store lands in the addressed word
        p_dev_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (dev_we && dev_idx == IDX_W'(i)) |=> (word_q[i] == $past(dev_wdata)));
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < BUF_WORDS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = word_q[i];
        end
    end
endmodule

// File: rtl/pmb_engine.sv
module pmb_engine
    import pmb_pkg::*;
#(
    parameter int DW        = 16,
    parameter int BUF_WORDS = 4,
    parameter int IDX_W     = 2,
    parameter int CNT_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [DW-1:0]    cmd_data,
    input  logic             buf_rd,
    input  logic             med_valid,
    input  logic [DW-1:0]    med_data,
    output logic             med_req,
    output logic             dev_we,
    output logic [IDX_W-1:0] dev_idx,
    output logic [DW-1:0]    dev_wdata,
    output logic             busy,
    output logic             done,
    output logic             err
);
    eng_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] idx_next;
    logic [CMD_CNT_W-1:0] req_n;
    logic [CNT_W-1:0] eff_n;
    logic start_ok, start_bad, take, last;

    always_comb begin
        req_n     = cmd_data[CMD_CNT_LO +: CMD_CNT_W];
        eff_n     = ((req_n == '0) || (int'(req_n) > BUF_WORDS)) ? CNT_W'(BUF_WORDS) : CNT_W'(req_n);
        start_ok  = cmd_wr && cmd_data[CMD_START] && (state_q == ENG_IDLE);
        start_bad = cmd_wr && cmd_data[CMD_START] && (state_q != ENG_IDLE);
        take      = (state_q == ENG_FETCH) && med_valid;
        idx_next  = CNT_W'(idx_q) + CNT_W'(1);
        last      = (idx_next == cnt_q);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE:   if (start_ok) state_d = ENG_FETCH;
            ENG_FETCH:  if (take && last) state_d = ENG_FINISH;
            ENG_FINISH: state_d = ENG_IDLE;
            default:    state_d = ENG_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        med_req   = (state_q == ENG_FETCH);
        dev_we    = take;
        dev_idx   = idx_q;
        dev_wdata = med_data;
        busy      = (state_q != ENG_IDLE);
    end

    // datapath and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            if (start_ok) begin
                cnt_q <= eff_n;
                idx_q <= '0;
            end else if (take) begin
                idx_q <= idx_q + IDX_W'(1);
            end
            if (state_q == ENG_FINISH)  done <= 1'b1;
            else if (start_ok || buf_rd) done <= 1'b0;
            if (start_bad) err <= 1'b1;
            else if (cmd_wr && cmd_data[CMD_ERRCLR]) err <= 1'b0;
        end
    end

    p_cmd_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> (busy && !done));
    p_cmd_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_bad |=> (err && $stable(cnt_q)));
    p_req_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && last) |=> !med_req);
    p_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_FINISH) |=> (done && !busy));
    p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && state_q != ENG_FINISH) |=> !done);
endmodule

// File: rtl/pmb_mailbox.sv
module pmb_mailbox
    import pmb_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h8000,
    parameter int BUF_WORDS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic [15:0] cpu_wdata,
    input  logic        cpu_wr,
    input  logic        cpu_rd,
    output logic [15:0] cpu_rdata,
    output logic        cpu_rvalid,
    output logic        irq_req,
    output logic        med_req,
    input  logic        med_valid,
    input  logic [15:0] med_data
);
    localparam int DW    = 16;
    localparam int AW    = 16;
    localparam int IDX_W = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;
    localparam int CNT_W = $clog2(BUF_WORDS + 1);

    logic hit, hit_stat, hit_buf;
    logic [IDX_W-1:0] buf_idx, dev_idx;
    logic [DW-1:0] buf_q, dev_wdata, status;
    logic dev_we, busy, done, err;

    pmb_decode #(.AW(AW), .BASE(BASE_ADDR), .BUF_WORDS(BUF_WORDS), .IDX_W(IDX_W)) u_decode (
        .addr(cpu_addr), .hit(hit), .hit_stat(hit_stat), .hit_buf(hit_buf), .buf_idx(buf_idx)
    );

    pmb_store #(.DW(DW), .BUF_WORDS(BUF_WORDS), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .cpu_we(cpu_wr && hit_buf), .cpu_idx(buf_idx), .cpu_wdata(cpu_wdata),
        .dev_we(dev_we), .dev_idx(dev_idx), .dev_wdata(dev_wdata),
        .rd_idx(buf_idx), .rd_data(buf_q)
    );

    pmb_engine #(.DW(DW), .BUF_WORDS(BUF_WORDS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cpu_wr && hit_stat), .cmd_data(cpu_wdata),
        .buf_rd(cpu_rd && hit_buf),
        .med_valid(med_valid), .med_data(med_data), .med_req(med_req),
        .dev_we(dev_we), .dev_idx(dev_idx), .dev_wdata(dev_wdata),
        .busy(busy), .done(done), .err(err)
    );

    always_comb begin
        status            = '0;
        status[STAT_BUSY] = busy;
        status[STAT_DONE] = done;
        status[STAT_ERR]  = err;
        irq_req           = done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rvalid <= 1'b0;
            cpu_rdata  <= '0;
        end else if (cpu_rd && hit) begin
            cpu_rvalid <= 1'b1;
            cpu_rdata  <= hit_stat ? status : buf_q;
        end else begin
            cpu_rvalid <= 1'b0;
            cpu_rdata  <= '0;
        end
    end

    p_outside_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !hit) |=> (!cpu_rvalid && cpu_rdata == '0));
    p_decode_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_stat, hit_buf}));
    p_inside_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && hit) |=> cpu_rvalid);
endmodule

// File: tb/test_pmb_mailbox.sv
module test_pmb_mailbox;
    localparam logic [15:0] BASE = 16'h8000;
    localparam int BW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0, cpu_rdata, med_data;
    logic cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_rvalid, irq_req, med_req, med_valid;

    int n_chk = 0;
    int n_err = 0;
    int unsigned src_k = 0;
    bit med_en = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pmb_mailbox #(.BASE_ADDR(BASE), .BUF_WORDS(BW)) i_pmb_mailbox (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
        .irq_req(irq_req), .med_req(med_req), .med_valid(med_valid), .med_data(med_data)
    );

    function automatic int eff_cnt(int n);
        return (n == 0 || n > BW) ? BW : n;
    endfunction

    function automatic logic [15:0] src_word(int unsigned k);
        return 16'(32'hA5C3 ^ (k * 32'h0131) ^ (k << 7));
    endfunction

    function automatic logic [15:0] stat_word(bit b, bit d, bit e);
        return {13'd0, e, d, b};
    endfunction

    task automatic check(bit ok, string req, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cpu_write(logic [15:0] a, logic [15:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(logic [15:0] a, output logic [15:0] d, output logic v);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        d = cpu_rdata; v = cpu_rvalid;
    endtask

    task automatic wait_irq(output bit ok);
        ok = 1'b0;
        for (int t = 0; t < 2000; t++) begin
            if (irq_req) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // medium model: random gaps, sequential words
    initial begin
        bit pv, pr;
        pv = 1'b0; pr = 1'b0;
        med_valid = 1'b0; med_data = '0;
        forever begin
            @(negedge clk);
            if (pv && pr) src_k++;
            pr = med_req;
            pv = med_en && med_req && ($urandom % 4 != 0);
            med_valid = pv;
            med_data = src_word(src_k);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R10 watchdog actual=hung expected=complete");
        summary();
    end

    initial begin
        logic [15:0] d;
        logic v;
        bit ok;
        int unsigned k0;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        check(irq_req == 1'b0, "R2", "irq after reset", 16'(irq_req), 16'h0);
        check(med_req == 1'b0, "R2", "med_req after reset", 16'(med_req), 16'h0);
        cpu_read(BASE, d, v);
        check(v && d == 16'h0, "R2", "status after reset", d, 16'h0);
        cpu_read(BASE + 16'd2, d, v);
        check(v && d == 16'h0, "R2", "buffer after reset", d, 16'h0);

        // R1 window boundaries
        cpu_read(BASE - 16'd1, d, v);
        check(!v && d == 16'h0, "R1", "read below window", {15'd0, v}, 16'h0);
        cpu_read(BASE + 16'd5, d, v);
        check(!v && d == 16'h0, "R1", "read above window", {15'd0, v}, 16'h0);
        cpu_write(BASE + 16'd5, 16'h8100);
        cpu_write(BASE - 16'd1, 16'h8100);
        cpu_read(BASE, d, v);
        check(v && d == 16'h0, "R1", "outside writes ignored", d, 16'h0);

        // R9 CPU buffer access
        for (int i = 0; i < BW; i++) cpu_write(BASE + 16'(i + 1), 16'(16'h0F0F + i * 16'h1111));
        for (int i = 0; i < BW; i++) begin
            cpu_read(BASE + 16'(i + 1), d, v);
            check(v && d == 16'(16'h0F0F + i * 16'h1111), "R9", "buffer readback", d, 16'(16'h0F0F + i * 16'h1111));
        end

        // R3 R5 R6 directed command of 3 words
        med_en = 1'b1;
        k0 = src_k;
        cpu_write(BASE, 16'h8300);
        check(med_req == 1'b1, "R5", "med_req after start", 16'(med_req), 16'h1);
        cpu_read(BASE, d, v);
        check(d == stat_word(1, 0, 0), "R3", "busy after start", d, stat_word(1, 0, 0));
        for (int t = 0; t < 2000 && med_req; t++) @(negedge clk);
        check(med_req == 1'b0 && irq_req == 1'b0, "R6", "irq low in finish cycle", 16'(irq_req), 16'h0);
        @(negedge clk);
        check(irq_req == 1'b1, "R6", "irq one cycle after req falls", 16'(irq_req), 16'h1);
        cpu_read(BASE, d, v);
        check(d == stat_word(0, 1, 0), "R6", "status done", d, stat_word(0, 1, 0));
        cpu_read(BASE, d, v);
        check(d == stat_word(0, 1, 0) && irq_req, "R7", "status read keeps done", d, stat_word(0, 1, 0));
        cpu_read(BASE + 16'd1, d, v);
        check(d == src_word(k0), "R4", "word 0", d, src_word(k0));
        check(irq_req == 1'b0, "R7", "buffer read clears irq", 16'(irq_req), 16'h0);
        cpu_read(BASE + 16'd2, d, v);
        check(d == src_word(k0 + 1), "R4", "word 1", d, src_word(k0 + 1));
        cpu_read(BASE + 16'd3, d, v);
        check(d == src_word(k0 + 2), "R4", "word 2", d, src_word(k0 + 2));
        cpu_read(BASE + 16'd4, d, v);
        check(d == 16'(16'h0F0F + 3 * 16'h1111), "R4", "word beyond count untouched", d, 16'(16'h0F0F + 3 * 16'h1111));

        // R8 start while busy
        med_en = 1'b0;
        for (int i = 0; i < BW; i++) cpu_write(BASE + 16'(i + 1), 16'hBEEF);
        k0 = src_k;
        cpu_write(BASE, 16'h8100);
        cpu_write(BASE, 16'h8400);
        cpu_read(BASE, d, v);
        check(d == stat_word(1, 0, 1), "R8", "error on busy start", d, stat_word(1, 0, 1));
        med_en = 1'b1;
        wait_irq(ok);
        check(ok, "R8", "first command completes", 16'(ok), 16'h1);
        cpu_read(BASE, d, v);
        check(d == stat_word(0, 1, 1), "R8", "status after completion", d, stat_word(0, 1, 1));
        cpu_read(BASE + 16'd1, d, v);
        check(d == src_word(k0), "R8", "single word filled", d, src_word(k0));
        for (int i = 1; i < BW; i++) begin
            cpu_read(BASE + 16'(i + 1), d, v);
            check(d == 16'hBEEF, "R8", "ignored command filled nothing", d, 16'hBEEF);
        end
        cpu_write(BASE, 16'h4000);
        cpu_read(BASE, d, v);
        check(d == stat_word(0, 0, 0), "R8", "error cleared", d, stat_word(0, 0, 0));

        // R10 random commands with R1 out-of-window probes
        for (int it = 0; it < 25; it++) begin
            int n;
            logic [15:0] a;
            n = int'($urandom % 16);
            a = 16'($urandom);
            if (a >= BASE && a < BASE + 16'd5) a = BASE + 16'd5 + {8'd0, a[7:0]};
            cpu_read(a, d, v);
            check(!v && d == 16'h0, "R1", "random outside read", {15'd0, v}, 16'h0);
            k0 = src_k;
            cpu_write(BASE, 16'h8000 | 16'(n << 8));
            wait_irq(ok);
            check(ok, "R10", "command completes", 16'(ok), 16'h1);
            for (int i = 0; i < eff_cnt(n); i++) begin
                cpu_read(BASE + 16'(i + 1), d, v);
                check(v && d == src_word(k0 + i), "R10", "random fill word", d, src_word(k0 + i));
            end
            cpu_read(BASE, d, v);
            check(d == stat_word(0, 0, 0), "R10", "status idle after read", d, stat_word(0, 0, 0));
        end

        summary();
    end
endmodule